// File: doc/BRIEF.md
# Packed SIMD and Complex Multiply Unit

This unit multiplies two 64-bit source words in one of eight modes chosen by a 3-bit operation code, and returns a 64-bit answer as a low and a high 32-bit half. The modes are a full 32x32 product, two independent 16x16 products, four 8x8 byte products, a four-way byte dot product, a sum-and-difference of two 16x16 products, a 16-bit complex product at full precision, the same complex product rounded and packed into one word, and a per-byte multiply over GF(2^8).

The multiply logic is purely combinational. A single output register follows it, so every mode has a latency of exactly one clock and a new operation can be issued on every cycle. A sign control selects two's complement or unsigned operands for the 32x32, dual 16x16 and sum/difference modes. The byte modes are always unsigned, the complex modes are always signed, and the Galois-field mode has no sign. The reduction polynomial of the field is a parameter.

Top module: `simd_cmul_unit`

## Requirements
- R1: While `rst` is high at a rising edge, both result halves become zero, whatever the inputs are.
- R2: Operands sampled at a rising edge produce their result at the outputs just after that edge. The result stays unchanged until the next edge.
- R3: Code 0 forms the 64-bit product of `src_a[31:0]` and `src_b[31:0]`. The operands are signed when `is_signed`=1 and unsigned otherwise. `res_lo` holds product bits 31:0 and `res_hi` holds bits 63:32.
- R4: Code 1 puts the 32-bit product of the low 16-bit halves of `src_a`/`src_b` on `res_lo`, and the product of bits 31:16 on `res_hi`. The sign of both products follows `is_signed`.
- R5: Code 2 multiplies the four byte lanes of `src_a[31:0]` and `src_b[31:0]` as unsigned values, giving 16-bit products. Lane 0 goes to `res_lo[15:0]`, lane 1 to `res_lo[31:16]`, lane 2 to `res_hi[15:0]` and lane 3 to `res_hi[31:16]`.
- R6: Code 3 puts the zero-extended sum of the four unsigned byte products of R5 on `res_lo`, and `res_hi` is zero.
- R7: Code 4 forms the two 16x16 lane products of R4. `res_lo` = upper-lane product + lower-lane product and `res_hi` = upper-lane product - lower-lane product, both modulo 2^32.
- R8: Code 5 treats bits 31:16 of each operand as a signed real part and bits 15:0 as a signed imaginary part. `res_hi` = ar*br - ai*bi and `res_lo` = ar*bi + ai*br, each taken modulo 2^32.
- R9: Code 6 computes both parts as in R8 at full precision. Each part is rounded as floor((x + 32768) / 65536) and saturated to [-32768, 32767]. The real result goes to `res_lo[31:16]` and the imaginary result to `res_lo[15:0]`, and `res_hi` is zero.
- R10: Code 7 multiplies each of the eight byte lanes of `src_a` and `src_b` in GF(2^8). The reduction polynomial is x^8 + x^4 + x^3 + x + 1, whose low byte is the parameter default 0x1B. Lanes 0..3 go to `res_lo` and lanes 4..7 go to `res_hi`, with lane n at bits 8n+7:8n of the 64-bit result.
- R11: `is_signed` has no effect on codes 2, 3, 5, 6 and 7.
- R12: Corner cases follow the rules above. With both operands 0x80008000, code 5 gives `res_hi`=0 and `res_lo`=0x80000000, and code 6 saturates to `res_lo`=0x00007FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code 0..7 (see R3 to R10) |
| is_signed | input | 1 | 1 selects two's complement for codes 0, 1 and 4 |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| res_lo | output | 32 | Registered low half of the result |
| res_hi | output | 32 | Registered high half of the result |

## Verification
The only state is the output register, so a fault shows at the ports on the very next edge. A wrong mode select or a wrong lane order shows as a misplaced field, such as a non-zero high half in the dot or rounded modes or a lane result in the wrong slot. A sign-extension slip shows only when operand top bits are set, so the edge-value sweep pairs 0x80000000, 0xFFFFFFFF and 0x7FFFFFFF in every mode. A wrong field polynomial or shift corrupts a subset of the 65536 byte pairs, and the sweep covers all of them.

// File: rtl/smu_pkg.sv
package smu_pkg;
  typedef enum logic [2:0] {
    OP_MUL32   = 3'd0,
    OP_MUL16X2 = 3'd1,
    OP_MUL8X4  = 3'd2,
    OP_DOT8    = 3'd3,
    OP_ADDSUB  = 3'd4,
    OP_CMPY    = 3'd5,
    OP_CMPYR   = 3'd6,
    OP_GF8     = 3'd7
  } smu_op_t;
endpackage

// File: rtl/smu_int_mul.sv
module smu_int_mul
  import smu_pkg::*;
#(
  parameter int HW = 32
) (
  input  smu_op_t         op,
  input  logic            sgn,
  input  logic [HW-1:0]   a,
  input  logic [HW-1:0]   b,
  output logic [HW-1:0]   lo,
  output logic [HW-1:0]   hi
);
  localparam int QW = HW / 2;
  localparam int EW = HW / 4;
  localparam int DW = 2 * EW + 2;

  // full-width product with selectable sign extension
  logic signed [HW:0]     ax, bx;
  logic signed [2*HW+1:0] pfull;
  assign ax    = {sgn & a[HW-1], a};
  assign bx    = {sgn & b[HW-1], b};
  assign pfull = (2*HW+2)'(ax) * (2*HW+2)'(bx);

  // two half-width lanes
  logic [HW-1:0] p16 [2];
  for (genvar i = 0; i < 2; i++) begin : g_half
    logic signed [QW:0]     hx, hy;
    logic signed [2*QW+1:0] hp;
    assign hx     = {sgn & a[QW*i+QW-1], a[QW*i +: QW]};
    assign hy     = {sgn & b[QW*i+QW-1], b[QW*i +: QW]};
    assign hp     = (2*QW+2)'(hx) * (2*QW+2)'(hy);
    assign p16[i] = hp[HW-1:0];
  end

  // four unsigned byte lanes
  logic [2*EW-1:0] p8 [4];
  for (genvar i = 0; i < 4; i++) begin : g_byte
    assign p8[i] = (2*EW)'(a[EW*i +: EW]) * (2*EW)'(b[EW*i +: EW]);
  end

  logic [DW-1:0] dot;
  assign dot = DW'(p8[0]) + DW'(p8[1]) + DW'(p8[2]) + DW'(p8[3]);

  always_comb begin
    lo = '0;
    hi = '0;
    case (op)
      OP_MUL32:   begin lo = pfull[HW-1:0]; hi = pfull[2*HW-1:HW]; end
      OP_MUL16X2: begin lo = p16[0]; hi = p16[1]; end
      OP_MUL8X4:  begin lo = {p8[1], p8[0]}; hi = {p8[3], p8[2]}; end
      OP_DOT8:    lo = HW'(dot);
      OP_ADDSUB:  begin lo = p16[1] + p16[0]; hi = p16[1] - p16[0]; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/smu_cplx.sv
module smu_cplx #(
  parameter int PW = 16
) (
  input  logic [2*PW-1:0] a,
  input  logic [2*PW-1:0] b,
  output logic [2*PW-1:0] re_o,
  output logic [2*PW-1:0] im_o,
  output logic [2*PW-1:0] packed_o
);
  localparam int FW = 2 * PW;
  localparam int XW = FW + 1;
  localparam int RW = FW + 2;
  localparam int SW = RW - PW;
  localparam logic signed [SW-1:0] SMAX = SW'((1 << (PW-1)) - 1);
  localparam logic signed [SW-1:0] SMIN = -SW'(1 << (PW-1));

  logic signed [PW-1:0] ar, ai, br, bi;
  assign ar = a[FW-1:PW];
  assign ai = a[PW-1:0];
  assign br = b[FW-1:PW];
  assign bi = b[PW-1:0];

  logic signed [FW-1:0] p_rr, p_ii, p_ri, p_ir;
  assign p_rr = FW'(ar) * FW'(br);
  assign p_ii = FW'(ai) * FW'(bi);
  assign p_ri = FW'(ar) * FW'(bi);
  assign p_ir = FW'(ai) * FW'(br);

  logic signed [XW-1:0] re, im;
  assign re   = XW'(p_rr) - XW'(p_ii);
  assign im   = XW'(p_ri) + XW'(p_ir);
  assign re_o = re[FW-1:0];
  assign im_o = im[FW-1:0];

  function automatic logic [PW-1:0] rnd_sat(input logic signed [XW-1:0] x);
    logic signed [RW-1:0] t;
    logic signed [SW-1:0] s;
    t = RW'(x) + RW'(1 << (PW-1));
    s = t[RW-1:PW];
    if (s > SMAX)      return SMAX[PW-1:0];
    else if (s < SMIN) return SMIN[PW-1:0];
    else               return s[PW-1:0];
  endfunction

  assign packed_o = {rnd_sat(re), rnd_sat(im)};
endmodule

// File: rtl/smu_gf_lane.sv
module smu_gf_lane #(
  parameter int          GW   = 8,
  parameter logic [GW-1:0] POLY = 8'h1B
) (
  input  logic [GW-1:0] x,
  input  logic [GW-1:0] y,
  output logic [GW-1:0] z
);
  // shift-and-add with reduction folded into each doubling step
  always_comb begin
    logic [GW-1:0] acc, sh;
    acc = '0;
    sh  = x;
    for (int k = 0; k < GW; k++) begin
      if (y[k]) acc = acc ^ sh;
      sh = sh[GW-1] ? ((sh << 1) ^ POLY) : (sh << 1);
    end
    z = acc;
  end
endmodule

// File: rtl/simd_cmul_unit.sv
module simd_cmul_unit
  import smu_pkg::*;
#(
  parameter int         DW      = 64,
  parameter logic [7:0] GF_POLY = 8'h1B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op,
  input  logic          is_signed,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  output logic [DW/2-1:0] res_lo,
  output logic [DW/2-1:0] res_hi
);
  localparam int HW    = DW / 2;
  localparam int LANES = DW / 8;

  smu_op_t opc;
  assign opc = smu_op_t'(op);

  logic [HW-1:0] int_lo, int_hi;
  smu_int_mul #(.HW(HW)) u_int (
    .op (opc),
    .sgn(is_signed),
    .a  (src_a[HW-1:0]),
    .b  (src_b[HW-1:0]),
    .lo (int_lo),
    .hi (int_hi)
  );

  logic [HW-1:0] cx_re, cx_im, cx_pk;
  smu_cplx #(.PW(HW/2)) u_cplx (
    .a       (src_a[HW-1:0]),
    .b       (src_b[HW-1:0]),
    .re_o    (cx_re),
    .im_o    (cx_im),
    .packed_o(cx_pk)
  );

  logic [DW-1:0] gf_res;
  for (genvar n = 0; n < LANES; n++) begin : g_gf
    smu_gf_lane #(.GW(8), .POLY(GF_POLY)) u_lane (
      .x(src_a[8*n +: 8]),
      .y(src_b[8*n +: 8]),
      .z(gf_res[8*n +: 8])
    );
  end

  logic [HW-1:0] nxt_lo, nxt_hi;
  always_comb begin
    case (opc)
      OP_CMPY:  begin nxt_lo = cx_im;          nxt_hi = cx_re; end
      OP_CMPYR: begin nxt_lo = cx_pk;          nxt_hi = '0; end
      OP_GF8:   begin nxt_lo = gf_res[HW-1:0]; nxt_hi = gf_res[DW-1:HW]; end
      default:  begin nxt_lo = int_lo;         nxt_hi = int_hi; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_lo <= '0;
      res_hi <= '0;
    end else begin
      res_lo <= nxt_lo;
      res_hi <= nxt_hi;
    end
  end
endmodule

// File: rtl/simd_cmul_unit_chk.sv
module simd_cmul_unit_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    op,
  input logic          is_signed,
  input logic [DW-1:0] src_a,
  input logic [DW-1:0] src_b,
  input logic [DW/2-1:0] res_lo,
  input logic [DW/2-1:0] res_hi
);
  logic rst_d1;
  logic armed;
  always_ff @(posedge clk) rst_d1 <= rst;
  assign armed = (rst_d1 == 1'b0);

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_d1 == 1'b1) |-> (res_lo == '0 && res_hi == '0));

  // R2
  steady_result_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $stable(op) && $stable(is_signed) && $stable(src_a) && $stable(src_b)
      |=> $stable(res_lo) && $stable(res_hi));

  // R5
  byte_prod_range_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op) == 3'd2 |->
      res_lo[15:0] <= 16'hFE01 && res_lo[31:16] <= 16'hFE01 &&
      res_hi[15:0] <= 16'hFE01 && res_hi[31:16] <= 16'hFE01);

  // R6
  dot_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op) == 3'd3 |-> res_hi == '0 && res_lo[31:18] == '0);

  // R9
  cmpyr_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op) == 3'd6 |-> res_hi == '0);
endmodule

bind simd_cmul_unit simd_cmul_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .op(op), .is_signed(is_signed),
  .src_a(src_a), .src_b(src_b), .res_lo(res_lo), .res_hi(res_hi)
);

// File: tb/simd_cmul_unit_test.sv
`timescale 1ns/1ps
module simd_cmul_unit_test;
  localparam logic [7:0] POLY = 8'h1B;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op;
  logic        is_signed;
  logic [63:0] src_a, src_b;
  logic [31:0] res_lo, res_hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  simd_cmul_unit uut (
    .clk(clk), .rst(rst), .op(op), .is_signed(is_signed),
    .src_a(src_a), .src_b(src_b), .res_lo(res_lo), .res_hi(res_hi)
  );

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic longint h16(input logic sg, input logic [15:0] x);
    longint v;
    if (sg) v = $signed(x); else v = {48'b0, x};
    return v;
  endfunction

  function automatic logic [7:0] gf_ref(input logic [7:0] x, input logic [7:0] y);
    logic [14:0] p = '0;
    for (int i = 0; i < 8; i++) if (y[i]) p = p ^ (15'(x) << i);
    for (int bt = 14; bt >= 8; bt--)
      if (p[bt]) p = p ^ (15'({1'b1, POLY}) << (bt - 8));
    return p[7:0];
  endfunction

  function automatic logic [15:0] rs_ref(input longint v);
    longint t;
    t = (v + 32768) >>> 16;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t[15:0];
  endfunction

  function automatic logic [63:0] model(input logic [2:0] o, input logic sg,
                                        input logic [63:0] a, input logic [63:0] b);
    longint sa, sb, p0, p1, re, im;
    logic [31:0] l, h;
    logic [15:0] q [4];
    l = '0; h = '0;
    for (int k = 0; k < 4; k++) q[k] = 16'(a[8*k +: 8]) * 16'(b[8*k +: 8]);
    p0 = h16(sg, a[15:0]) * h16(sg, b[15:0]);
    p1 = h16(sg, a[31:16]) * h16(sg, b[31:16]);
    re = h16(1'b1, a[31:16]) * h16(1'b1, b[31:16]) - h16(1'b1, a[15:0]) * h16(1'b1, b[15:0]);
    im = h16(1'b1, a[31:16]) * h16(1'b1, b[15:0]) + h16(1'b1, a[15:0]) * h16(1'b1, b[31:16]);
    case (o)
      3'd0: begin
        if (sg) begin sa = $signed(a[31:0]); sb = $signed(b[31:0]); end
        else begin sa = {32'b0, a[31:0]}; sb = {32'b0, b[31:0]}; end
        sa = sa * sb;
        l = sa[31:0]; h = sa[63:32];
      end
      3'd1: begin l = p0[31:0]; h = p1[31:0]; end
      3'd2: begin l = {q[1], q[0]}; h = {q[3], q[2]}; end
      3'd3: l = 32'(q[0]) + 32'(q[1]) + 32'(q[2]) + 32'(q[3]);
      3'd4: begin sa = p1 + p0; sb = p1 - p0; l = sa[31:0]; h = sb[31:0]; end
      3'd5: begin l = im[31:0]; h = re[31:0]; end
      3'd6: l = {rs_ref(re), rs_ref(im)};
      default: begin
        for (int k = 0; k < 4; k++) begin
          l[8*k +: 8] = gf_ref(a[8*k +: 8], b[8*k +: 8]);
          h[8*k +: 8] = gf_ref(a[32+8*k +: 8], b[32+8*k +: 8]);
        end
      end
    endcase
    return {h, l};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [2:0] o, input logic sg,
                     input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op = o; is_signed = sg; src_a = a; src_b = b;
    @(posedge clk);
    #1;
    check(tag, {res_hi, res_lo}, model(o, sg, a, b));
  endtask

  logic [63:0] edges [6];

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    edges[0] = 64'h0;
    edges[1] = 64'h1;
    edges[2] = 64'h7FFF_FFFF_7FFF_FFFF;
    edges[3] = 64'h8000_0000_8000_0000;
    edges[4] = 64'hFFFF_FFFF_FFFF_FFFF;
    edges[5] = 64'h8000_7FFF_7FFF_8000;

    // R1: reset clears the outputs even with live operands
    rst = 1'b1; op = 3'd0; is_signed = 1'b0;
    src_a = 64'hFFFF_FFFF_FFFF_FFFF; src_b = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(posedge clk);
    #1 check("R1", {res_hi, res_lo}, 64'h0);
    @(negedge clk) rst = 1'b0;

    // R2: the result appears only after the next edge
    run("R2", 3'd0, 1'b0, 64'd3, 64'd5);
    @(negedge clk);
    op = 3'd0; src_a = 64'd7; src_b = 64'd9;
    #1 check("R2", {res_hi, res_lo}, 64'd15);
    @(posedge clk);
    #1 check("R2", {res_hi, res_lo}, 64'd63);

    // R12: complex corner cases
    run("R12", 3'd5, 1'b1, 64'h8000_8000, 64'h8000_8000);
    check("R12", {res_hi, res_lo}, 64'h0000_0000_8000_0000);
    run("R12", 3'd6, 1'b0, 64'h8000_8000, 64'h8000_8000);
    check("R12", {res_hi, res_lo}, 64'h0000_0000_0000_7FFF);

    // R10: known field products
    run("R10", 3'd7, 1'b0, 64'h57, 64'h83);
    check("R10", {res_hi, res_lo}, 64'hC1);
    run("R10", 3'd7, 1'b0, 64'h57, 64'h13);
    check("R10", {res_hi, res_lo}, 64'hFE);

    // edge operands in every mode and both sign settings
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            run(req_of(3'(o)), 3'(o), 1'(s), edges[i], edges[j]);

    // random operands in every mode
    for (int o = 0; o < 7; o++)
      for (int n = 0; n < 400; n++)
        run(req_of(3'(o)), 3'(o), 1'(n & 1),
            {$urandom(), $urandom()}, {$urandom(), $urandom()});

    // R11: sign control is ignored by byte, complex and field modes
    for (int n = 0; n < 100; n++) begin
      logic [63:0] ra, rb;
      logic [2:0]  rop;
      ra = {$urandom(), $urandom()} | 64'h8080_8080_8080_8080;
      rb = {$urandom(), $urandom()} | 64'h8080_8080_8080_8080;
      case (n % 5)
        0: rop = 3'd2;
        1: rop = 3'd3;
        2: rop = 3'd5;
        3: rop = 3'd6;
        default: rop = 3'd7;
      endcase
      run("R11", rop, 1'b0, ra, rb);
      run("R11", rop, 1'b1, ra, rb);
    end

    // R10: every byte pair, eight lanes per vector
    for (int x = 0; x < 256; x++)
      for (int yb = 0; yb < 32; yb++) begin
        logic [63:0] va, vb;
        for (int k = 0; k < 8; k++) begin
          va[8*k +: 8] = 8'(x);
          vb[8*k +: 8] = 8'(yb * 8 + k);
        end
        run("R10", 3'd7, 1'(yb & 1), va, vb);
      end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule